// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a PWM modulator and the output pins and decides, cycle by cycle, whether each PWM line follows the modulator or is held at a programmed safe level. Three hardware sources can trip it: two active-low external trip pins, which enter through a synchronizer, and an on-chip over-current comparator. A software kill bit can also force the outputs off. The modulator's counter is outside this block and is never stopped by it.

Each hardware source has its own enable and its own recovery style. In auto-recover style, the outputs come back at the first PWM period boundary after the source goes quiet, which gives pulse-by-pulse current limiting without partial pulses. In latched style, the outputs stay forced until software issues a re-arm strobe. A re-arm strobe is ignored while any enabled source is still asserting. A sticky status register records which sources tripped and is cleared by writing ones. A one-cycle interrupt pulse marks each new trip.

Top module: `pwm_trip_guard`

## Requirements
- R1: A low level on either trip pin with its enable set forces every output to its `off_level` bit. This takes effect after the second rising clock edge that samples the pin low, and not before.
- R2: A high `ocp_cmp` with its enable set forces the outputs to `off_level` in the same cycle, with no register delay.
- R3: While `sw_off` is high, `pwm_out` equals `off_level` whatever the source enables are. `sw_off` sets no status bit and raises no interrupt. When `sw_off` drops with no hold pending, `pwm_out` follows `pwm_in` again at once.
- R4: A source whose enable bit is 0 does not change the outputs, the interrupt or the status register.
- R5: An output whose `out_en` bit is 0 always drives its `off_level` bit. An output whose `out_en` bit is 1 follows `pwm_in` when no trip is in force.
- R6: For a source in auto-recover style (`src_auto` bit = 1), the outputs stay forced after the source deasserts. They resume in the cycle after the first clock edge at which `period_end` is high and the source is inactive. A `period_end` seen while the source is still active releases nothing.
- R7: For a source in latched style (`src_auto` bit = 0), `period_end` releases nothing. The outputs resume in the cycle after a clock edge that samples `rearm` high.
- R8: A `rearm` strobe sampled while any enabled source is active has no effect. A latched hold survives that strobe after the source drops.
- R9: `fault_irq` is high for exactly one cycle, one clock edge after an enabled source becomes active. It does not repeat while that source stays active.
- R10: `fault_stat` bit 0 is trip pin 0, bit 1 is trip pin 1 and bit 2 is the comparator. A bit is set one edge after its source becomes active while enabled, and stays set until a clock edge samples a 1 in the same bit of `stat_clr`. Bits with a 0 in `stat_clr` are kept. A new trip in the same cycle as the clear leaves the bit set.
- R11: During and after reset, `fault_stat` is 0, `fault_irq` is 0, no hold is pending and the synchronized pins read as not tripped, so `pwm_out` follows the gating rules of R5.
- R12: Clearing a source's enable drops any hold that source has pending, one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | NUM_OUT | Modulator outputs before gating |
| period_end | input | 1 | One-cycle strobe at each PWM period boundary |
| trip_pin_n | input | 2 | Asynchronous active-low external trip pins |
| ocp_cmp | input | 1 | Over-current comparator, active high, synchronous |
| sw_off | input | 1 | Software kill bit, level sensitive |
| src_en | input | 3 | Per-source enable (bit 0 pin 0, bit 1 pin 1, bit 2 comparator) |
| src_auto | input | 3 | Per-source recovery: 1 auto-recover at period boundary, 0 latched |
| out_en | input | NUM_OUT | Per-output enable |
| off_level | input | NUM_OUT | Per-output safe level |
| rearm | input | 1 | Software re-arm strobe for latched holds |
| stat_clr | input | 3 | Write-one-to-clear strobe for the status bits |
| pwm_out | output | NUM_OUT | Gated PWM outputs |
| fault_irq | output | 1 | One-cycle trip interrupt pulse |
| fault_stat | output | 3 | Sticky trip status |

## Verification
A hold bit stuck at 1 shows as outputs pinned at `off_level` after a trip has cleared and `period_end` or `rearm` has been given. A hold bit stuck at 0 shows as the outputs resuming in the very cycle a trip source drops. Either error is visible one cycle after the releasing edge. A wrong edge-detect register shows as a repeated or missing `fault_irq` pulse, or as a status bit not set, one edge after onset. An extra or missing synchronizer stage moves the forced cycle of a pin trip by one edge, which the pin-latency checks catch directly.

// File: rtl/pwm_trip_pkg.sv
`timescale 1ns/1ps
package pwm_trip_pkg;
    localparam int unsigned EXT_PINS  = 2;
    localparam int unsigned TRIP_SRCS = EXT_PINS + 1;
    localparam int unsigned SRC_PIN0  = 0;
    localparam int unsigned SRC_PIN1  = 1;
    localparam int unsigned SRC_OCP   = 2;

    typedef logic [TRIP_SRCS-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t hold;   // source keeps outputs forced
        src_vec_t prev;   // enabled-active view from last cycle
        src_vec_t stat;   // sticky trip record
        logic     irq;    // interrupt pulse
    } src_state_t;
endpackage

// File: rtl/trip_sync.sv
`timescale 1ns/1ps
module trip_sync #(
    parameter int unsigned W       = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{ {W{RST_VAL}} }};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/trip_src_ctl.sv
`timescale 1ns/1ps
module trip_src_ctl
    import pwm_trip_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t active,
    input  src_vec_t en,
    input  src_vec_t auto_mode,
    input  logic     period_end,
    input  logic     rearm,
    input  src_vec_t stat_clr,
    output logic     trip_any,
    output logic     irq,
    output src_vec_t stat
);
    src_state_t s_d, s_q;
    src_vec_t   act_en;
    src_vec_t   onset;
    logic       any_live;

    always_comb begin
        act_en   = active & en;
        onset    = act_en & ~s_q.prev;
        any_live = |act_en;
        s_d      = s_q;
        for (int i = 0; i < TRIP_SRCS; i++) begin
            if (!en[i])
                s_d.hold[i] = 1'b0;
            else if (act_en[i])
                s_d.hold[i] = 1'b1;
            else if (s_q.hold[i]) begin
                if (auto_mode[i]) s_d.hold[i] = !period_end;
                else              s_d.hold[i] = !(rearm && !any_live);
            end
        end
        s_d.prev = act_en;
        s_d.stat = (s_q.stat & ~stat_clr) | onset;
        s_d.irq  = |onset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trip_any = any_live | (|s_q.hold);
    assign irq      = s_q.irq;
    assign stat     = s_q.stat;

    for (genvar g = 0; g < TRIP_SRCS; g++) begin : g_chk
        assert_active_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            act_en[g] |=> s_q.hold[g]);
        assert_latched_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.hold[g] && en[g] && !auto_mode[g] && !rearm) |=> s_q.hold[g]);
        assert_rearm_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.hold[g] && en[g] && !auto_mode[g] && rearm && any_live) |=> s_q.hold[g]);
        assert_disable_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !en[g] |=> !s_q.hold[g]);
        assert_stat_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.stat[g] && !stat_clr[g]) |=> s_q.stat[g]);
    end
endmodule

// File: rtl/pwm_out_gate.sv
`timescale 1ns/1ps
module pwm_out_gate #(
    parameter int unsigned NUM_OUT = 6
) (
    input  logic [NUM_OUT-1:0] pwm_in,
    input  logic [NUM_OUT-1:0] out_en,
    input  logic [NUM_OUT-1:0] off_level,
    input  logic               force_off,
    output logic [NUM_OUT-1:0] pwm_out
);
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_lane
        assign pwm_out[j] = (out_en[j] && !force_off) ? pwm_in[j] : off_level[j];
    end
endmodule

// File: rtl/pwm_trip_guard.sv
`timescale 1ns/1ps
module pwm_trip_guard
    import pwm_trip_pkg::*;
#(
    parameter int unsigned NUM_OUT     = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] pwm_in,
    input  logic               period_end,
    input  logic [1:0]         trip_pin_n,
    input  logic               ocp_cmp,
    input  logic               sw_off,
    input  logic [2:0]         src_en,
    input  logic [2:0]         src_auto,
    input  logic [NUM_OUT-1:0] out_en,
    input  logic [NUM_OUT-1:0] off_level,
    input  logic               rearm,
    input  logic [2:0]         stat_clr,
    output logic [NUM_OUT-1:0] pwm_out,
    output logic               fault_irq,
    output logic [2:0]         fault_stat
);
    logic [EXT_PINS-1:0] pin_sync;
    src_vec_t            src_active;
    logic                trip_any;
    logic                force_off;

    trip_sync #(
        .W       (EXT_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trip_pin_n),
        .dout (pin_sync)
    );

    always_comb begin
        src_active                    = '0;
        src_active[SRC_PIN0]          = ~pin_sync[0];
        src_active[SRC_PIN1]          = ~pin_sync[1];
        src_active[SRC_OCP]           = ocp_cmp;
    end

    trip_src_ctl u_src_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (src_active),
        .en        (src_en),
        .auto_mode (src_auto),
        .period_end(period_end),
        .rearm     (rearm),
        .stat_clr  (stat_clr),
        .trip_any  (trip_any),
        .irq       (fault_irq),
        .stat      (fault_stat)
    );

    assign force_off = sw_off | trip_any;

    pwm_out_gate #(.NUM_OUT(NUM_OUT)) u_gate (
        .pwm_in   (pwm_in),
        .out_en   (out_en),
        .off_level(off_level),
        .force_off(force_off),
        .pwm_out  (pwm_out)
    );

    assert_swoff_forces_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off |-> (pwm_out == off_level));
    assert_idle_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((pwm_out ^ off_level) & ~out_en) == '0));
    assert_ocp_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_cmp && src_en[2]) |-> (pwm_out == off_level));
endmodule

// File: tb/pwm_trip_guard_tb.sv
`timescale 1ns/1ps
module pwm_trip_guard_tb;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pwm_in, out_en, off_level, pwm_out;
    logic         period_end, ocp_cmp, sw_off, rearm, fault_irq;
    logic [1:0]   trip_pin_n;
    logic [2:0]   src_en, src_auto, stat_clr, fault_stat;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    pwm_trip_guard #(.NUM_OUT(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_end(period_end),
        .trip_pin_n(trip_pin_n), .ocp_cmp(ocp_cmp), .sw_off(sw_off),
        .src_en(src_en), .src_auto(src_auto), .out_en(out_en),
        .off_level(off_level), .rearm(rearm), .stat_clr(stat_clr),
        .pwm_out(pwm_out), .fault_irq(fault_irq), .fault_stat(fault_stat)
    );

    // {sw_off, ocp, en[2:0], out_en, off_level, pwm_in, expected}
    localparam logic [28:0] VEC [8] = '{
        {1'b0,1'b0,3'b111,6'b111111,6'b000000,6'b101010,6'b101010},
        {1'b1,1'b0,3'b000,6'b111111,6'b000000,6'b101010,6'b000000},
        {1'b1,1'b0,3'b111,6'b111111,6'b110011,6'b101010,6'b110011},
        {1'b0,1'b1,3'b100,6'b111111,6'b001100,6'b111111,6'b001100},
        {1'b0,1'b1,3'b011,6'b111111,6'b000000,6'b010101,6'b010101},
        {1'b0,1'b0,3'b111,6'b000111,6'b101000,6'b111111,6'b101111},
        {1'b1,1'b0,3'b111,6'b000111,6'b010101,6'b000000,6'b010101},
        {1'b0,1'b0,3'b111,6'b110000,6'b001111,6'b011010,6'b011111}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; pwm_in = 6'b101010; out_en = '1; off_level = '0;
        period_end = 0; ocp_cmp = 0; sw_off = 0; rearm = 0;
        trip_pin_n = 2'b11; src_en = 3'b111; src_auto = 3'b111; stat_clr = 0;
        repeat (3) nx();
        chk("R11 stat in reset", fault_stat, 0);
        chk("R11 irq in reset", fault_irq, 0);
        chk("R11 out in reset", pwm_out, 6'b101010);
        rst_n = 1;
        nx();
        chk("R11 out after reset", pwm_out, 6'b101010);

        // table walk: R2 R3 R4 R5 gating
        for (int v = 0; v < 8; v++) begin
            sw_off = VEC[v][28]; ocp_cmp = VEC[v][27]; src_en = VEC[v][26:24];
            out_en = VEC[v][23:18]; off_level = VEC[v][17:12]; pwm_in = VEC[v][11:6];
            #1;
            chk($sformatf("gating R2 R3 R4 R5 vec %0d", v), pwm_out, VEC[v][5:0]);
            ocp_cmp = 0; sw_off = 0;
            nx();
        end
        src_en = 3'b111; out_en = '1; off_level = '0; pwm_in = 6'b101010;
        stat_clr = 3'b111; nx(); stat_clr = 0; nx();

        // pin 0, auto-recover
        trip_pin_n = 2'b10;
        nx(); chk("R1 pin0 not before two edges", pwm_out, 6'b101010);
        nx(); chk("R1 pin0 forced", pwm_out, 6'b000000);
        chk("R9 no irq yet", fault_irq, 0);
        nx(); chk("R9 irq pulse", fault_irq, 1);
        chk("R10 stat pin0", fault_stat, 3'b001);
        period_end = 1;
        nx(); period_end = 0;
        chk("R9 irq single", fault_irq, 0);
        chk("R6 period_end while active", pwm_out, 6'b000000);
        trip_pin_n = 2'b11;
        nx(); nx();
        chk("R6 held after clear", pwm_out, 6'b000000);
        period_end = 1;
        nx(); period_end = 0;
        chk("R6 resume at boundary", pwm_out, 6'b101010);
        chk("R10 sticky", fault_stat, 3'b001);
        stat_clr = 3'b010; nx(); stat_clr = 0;
        chk("R10 other bit kept", fault_stat, 3'b001);
        stat_clr = 3'b001; nx(); stat_clr = 0;
        chk("R10 cleared", fault_stat, 3'b000);

        // pin 1, latched
        src_auto = 3'b101;
        trip_pin_n = 2'b01;
        nx(); nx(); chk("R1 pin1 forced", pwm_out, 6'b000000);
        nx(); chk("R10 stat pin1", fault_stat, 3'b010);
        trip_pin_n = 2'b11;
        nx(); nx();
        period_end = 1; nx(); period_end = 0;
        chk("R7 boundary does not release", pwm_out, 6'b000000);
        rearm = 1; nx(); rearm = 0;
        chk("R7 rearm releases", pwm_out, 6'b101010);
        stat_clr = 3'b111; nx(); stat_clr = 0;

        // comparator, latched, rearm while active
        src_auto = 3'b001;
        ocp_cmp = 1; #1;
        chk("R2 same cycle", pwm_out, 6'b000000);
        nx();
        chk("R9 irq ocp", fault_irq, 1);
        rearm = 1; nx(); rearm = 0;
        ocp_cmp = 0; nx();
        chk("R8 rearm ignored while active", pwm_out, 6'b000000);
        rearm = 1; nx(); rearm = 0;
        chk("R8 later rearm works", pwm_out, 6'b101010);

        // onset vs clear in same cycle
        ocp_cmp = 1; stat_clr = 3'b100; nx(); stat_clr = 0;
        chk("R10 onset beats clear", fault_stat, 3'b100);
        ocp_cmp = 0; nx();
        chk("R12 hold present", pwm_out, 6'b000000);
        src_en = 3'b011; nx();
        chk("R12 disable drops hold", pwm_out, 6'b101010);
        src_en = 3'b111; nx();
        chk("R12 stays released", pwm_out, 6'b101010);
        stat_clr = 3'b111; nx(); stat_clr = 0;

        // disabled pin has no effect
        src_en = 3'b110; trip_pin_n = 2'b10;
        nx(); nx(); nx();
        chk("R4 disabled pin out", pwm_out, 6'b101010);
        chk("R4 disabled pin irq", fault_irq, 0);
        chk("R4 disabled pin stat", fault_stat, 0);
        trip_pin_n = 2'b11; nx(); nx();
        src_en = 3'b111; nx();

        // software kill leaves status alone
        sw_off = 1; nx(); nx();
        chk("R3 kill forces", pwm_out, 6'b000000);
        chk("R3 kill no stat", fault_stat, 0);
        chk("R3 kill no irq", fault_irq, 0);
        sw_off = 0; #1;
        chk("R3 kill release", pwm_out, 6'b101010);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule